// File: doc/BRIEF.md
# Cross-Core Flag Counter Synchronizer

This block lets one matrix core and two vector cores order their work against each other through numbered event flags. A core that has produced something issues a set request naming a flag number and a pairing mode; a core that must not proceed until that event has happened issues a wait request with the same flag number and mode. The block keeps a small saturating counter for every combination of mode, producing side, consuming core and flag number. A set adds one event to each counter its mode routes it to. A wait takes one event away and is released, or stalls while no event is available.

Sets are single-cycle pulses with no back-pressure: a set is always accepted. Waits use a valid/ready handshake: the core raises `*_wait_valid` with a stable mode, flag number and peer select, and the wait completes in the cycle where the matching ready is high. While ready is low the core holds its request. A core may drop valid before ready; this withdraws the wait and leaves every counter unchanged. The ready output is decided in the same cycle as the request, so a set and a wait that meet in one cycle complete together. Counter overflow is reported on a sticky error pin that stays high until reset.

Top module: `xcore_flag_sync`

## Requirements
- R1: After reset every counter holds zero, `ovf_err` is low, and no wait is released until a set that routes to its counter has been seen. Reset also clears `ovf_err`.
- R2: Each set adds one to each counter it is routed to. Each released wait removes one. So N stored sets release exactly N waits on the same counter, and the next wait stalls.
- R3: A wait whose required counters are not all available keeps its ready low for as long as it is held.
- R4: A counter saturates at 15. A set arriving while it is at 15 with no release in the same cycle is lost, and it raises `ovf_err` from the next cycle until reset.
- R5: If a set and a wait meet on a zero counter in the same cycle, the wait is released in that cycle and the counter stays at zero. A set and a release on a counter at 15 leave it at 15 without overflow.
- R6: Mode code 0 (vector pair): a set from either vector core counts toward both vector cores. A vector wait needs one event from each vector core and consumes both. Matrix requests in this mode have no effect and matrix waits are never released.
- R7: Mode code 1 (fan): one matrix set gives one event to each vector core. Each vector core consumes its own event independently.
- R8: Mode code 1 (fan), reverse direction: a matrix wait is released only when both vector cores have an event outstanding toward it, and the release consumes one from each.
- R9: Mode code 2 (one-to-one): the matrix peer bit selects vector core 0 (peer=0) or vector core 1 (peer=1). A matrix set goes only to that vector. A matrix wait consumes only events set by that vector. Each vector set or wait pairs only with the matrix core.
- R10: The same flag number used under different modes names different counters. A set in one mode never releases a wait in another mode.
- R11: Flag numbers 11 and above, and mode code 3, are ignored. Such sets change no counter, and such waits are never released.
- R12: Ready is high only while the corresponding valid is high. A withdrawn wait has no effect on any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| m_set_valid | input | 1 | Matrix core set pulse |
| m_set_mode | input | 2 | Mode of the matrix set |
| m_set_id | input | 4 | Flag number of the matrix set |
| m_set_peer | input | 1 | Target vector for a one-to-one matrix set |
| v_set_valid | input | 2 | Set pulse per vector core (bit i = vector i) |
| v_set_mode | input | 4 | Mode per vector core, 2 bits each |
| v_set_id | input | 8 | Flag number per vector core, 4 bits each |
| m_wait_valid | input | 1 | Matrix core wait request |
| m_wait_mode | input | 2 | Mode of the matrix wait |
| m_wait_id | input | 4 | Flag number of the matrix wait |
| m_wait_peer | input | 1 | Source vector for a one-to-one matrix wait |
| m_wait_ready | output | 1 | Matrix wait released this cycle |
| v_wait_valid | input | 2 | Wait request per vector core |
| v_wait_mode | input | 4 | Wait mode per vector core, 2 bits each |
| v_wait_id | input | 8 | Wait flag number per vector core, 4 bits each |
| v_wait_ready | output | 2 | Wait released per vector core |
| ovf_err | output | 1 | Sticky counter overflow flag |

## Verification
The bench targets the cycles where a set and a wait land together on an empty counter. A design that updated the count before deciding release would stall that waiter for a cycle or let the counter drift below zero. The two-party releases (vector pair and fan toward the matrix) are driven with only one party's event present. A design that checked just one source would release early, and one that decremented before both were present would lose an event. Sixteen sets on one counter are used to confirm that the 16th is dropped, that the error flag rises and sticks, and that exactly fifteen releases follow. Reused flag numbers across modes, out-of-range numbers, the reserved mode code and withdrawn waits are mixed into a long random phase, checking that no foreign or ignored request changes a count.

// File: rtl/xfs_pkg.sv
package xfs_pkg;
  localparam int NV = 2;

  typedef enum logic [1:0] {
    MD_VPAIR = 2'd0,
    MD_FAN   = 2'd1,
    MD_PAIR  = 2'd2,
    MD_RSVD  = 2'd3
  } xfs_mode_e;

  typedef struct packed {
    logic vpair;
    logic fan;
    logic pair;
  } xfs_msel_t;

  // counter bank map: vector-pair banks are destination-major
  localparam int B_VP    = 0;   // src Vj -> dst Vi : B_VP + 2*i + j
  localparam int B_FM    = 4;   // fan, matrix -> Vi
  localparam int B_FV    = 6;   // fan, Vi -> matrix
  localparam int B_PM    = 8;   // one-to-one, matrix -> Vi
  localparam int B_PV    = 10;  // one-to-one, Vi -> matrix
  localparam int NBANK   = 12;
endpackage

// File: rtl/xfs_req_dec.sv
module xfs_req_dec
  import xfs_pkg::*;
#(
  parameter int N_FLAGS = 11,
  parameter int ID_W    = 4
) (
  input  logic              valid,
  input  logic [1:0]        mode,
  input  logic [ID_W-1:0]   id,
  output logic [N_FLAGS-1:0] hit,
  output xfs_msel_t         sel
);
  always_comb begin
    for (int k = 0; k < N_FLAGS; k++) begin
      hit[k] = valid && (id == ID_W'(k));
    end
  end

  always_comb begin
    sel.vpair = (xfs_mode_e'(mode) == MD_VPAIR);
    sel.fan   = (xfs_mode_e'(mode) == MD_FAN);
    sel.pair  = (xfs_mode_e'(mode) == MD_PAIR);
  end
endmodule

// File: rtl/xfs_cnt_bank.sv
module xfs_cnt_bank #(
  parameter int N_FLAGS = 11,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] inc,
  input  logic [N_FLAGS-1:0] dec,
  output logic [N_FLAGS-1:0] avail,
  output logic               sat_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [N_FLAGS-1:0] sat_v;

  for (genvar k = 0; k < N_FLAGS; k++) begin : g_ctr
    logic [CNT_W-1:0] cnt_q;
    logic             take;

    assign take     = dec[k] && avail[k];
    assign avail[k] = (cnt_q != '0) || inc[k];
    assign sat_v[k] = inc[k] && !take && (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (inc[k] && !take) begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end else if (take && !inc[k]) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign sat_hit = |sat_v;
endmodule

// File: rtl/xcore_flag_sync.sv
module xcore_flag_sync
  import xfs_pkg::*;
#(
  parameter int  N_FLAGS = 11,
  parameter int  CNT_W   = 4,
  localparam int ID_W    = $clog2(N_FLAGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 m_set_valid,
  input  logic [1:0]           m_set_mode,
  input  logic [ID_W-1:0]      m_set_id,
  input  logic                 m_set_peer,
  input  logic [NV-1:0]        v_set_valid,
  input  logic [2*NV-1:0]      v_set_mode,
  input  logic [NV*ID_W-1:0]   v_set_id,
  input  logic                 m_wait_valid,
  input  logic [1:0]           m_wait_mode,
  input  logic [ID_W-1:0]      m_wait_id,
  input  logic                 m_wait_peer,
  output logic                 m_wait_ready,
  input  logic [NV-1:0]        v_wait_valid,
  input  logic [2*NV-1:0]      v_wait_mode,
  input  logic [NV*ID_W-1:0]   v_wait_id,
  output logic [NV-1:0]        v_wait_ready,
  output logic                 ovf_err
);
  // request decode
  logic [N_FLAGS-1:0] ms_hit, mw_hit;
  xfs_msel_t          ms_sel, mw_sel;
  logic [N_FLAGS-1:0] vs_hit [NV];
  logic [N_FLAGS-1:0] vw_hit [NV];
  xfs_msel_t          vs_sel [NV];
  xfs_msel_t          vw_sel [NV];

  xfs_req_dec #(.N_FLAGS(N_FLAGS), .ID_W(ID_W)) u_dec_ms (
    .valid(m_set_valid), .mode(m_set_mode), .id(m_set_id), .hit(ms_hit), .sel(ms_sel));
  xfs_req_dec #(.N_FLAGS(N_FLAGS), .ID_W(ID_W)) u_dec_mw (
    .valid(m_wait_valid), .mode(m_wait_mode), .id(m_wait_id), .hit(mw_hit), .sel(mw_sel));

  for (genvar i = 0; i < NV; i++) begin : g_vdec
    xfs_req_dec #(.N_FLAGS(N_FLAGS), .ID_W(ID_W)) u_dec_vs (
      .valid(v_set_valid[i]), .mode(v_set_mode[2*i +: 2]),
      .id(v_set_id[ID_W*i +: ID_W]), .hit(vs_hit[i]), .sel(vs_sel[i]));
    xfs_req_dec #(.N_FLAGS(N_FLAGS), .ID_W(ID_W)) u_dec_vw (
      .valid(v_wait_valid[i]), .mode(v_wait_mode[2*i +: 2]),
      .id(v_wait_id[ID_W*i +: ID_W]), .hit(vw_hit[i]), .sel(vw_sel[i]));
  end

  // counter banks
  logic [N_FLAGS-1:0] inc   [NBANK];
  logic [N_FLAGS-1:0] dec   [NBANK];
  logic [N_FLAGS-1:0] avail [NBANK];
  logic [NBANK-1:0]   sat_v;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    xfs_cnt_bank #(.N_FLAGS(N_FLAGS), .CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .inc(inc[b]), .dec(dec[b]),
      .avail(avail[b]), .sat_hit(sat_v[b]));
  end

  // set routing
  always_comb begin
    for (int b = 0; b < NBANK; b++) inc[b] = '0;
    if (ms_sel.fan) begin
      for (int i = 0; i < NV; i++) inc[B_FM + i] = inc[B_FM + i] | ms_hit;
    end
    if (ms_sel.pair) begin
      inc[B_PM + int'(m_set_peer)] = inc[B_PM + int'(m_set_peer)] | ms_hit;
    end
    for (int j = 0; j < NV; j++) begin
      if (vs_sel[j].vpair) begin
        for (int i = 0; i < NV; i++) begin
          inc[B_VP + 2*i + j] = inc[B_VP + 2*i + j] | vs_hit[j];
        end
      end
      if (vs_sel[j].fan)  inc[B_FV + j] = inc[B_FV + j] | vs_hit[j];
      if (vs_sel[j].pair) inc[B_PV + j] = inc[B_PV + j] | vs_hit[j];
    end
  end

  // wait release and consumption
  logic m_fan_ok, m_pair_ok;
  logic [NV-1:0] v_vp_ok, v_fan_ok, v_pair_ok;

  always_comb begin
    for (int b = 0; b < NBANK; b++) dec[b] = '0;

    m_fan_ok     = |(mw_hit & avail[B_FV] & avail[B_FV + 1]);
    m_pair_ok    = |(mw_hit & avail[B_PV + int'(m_wait_peer)]);
    m_wait_ready = (mw_sel.fan && m_fan_ok) || (mw_sel.pair && m_pair_ok);
    if (m_wait_ready) begin
      if (mw_sel.fan) begin
        dec[B_FV]     = mw_hit;
        dec[B_FV + 1] = mw_hit;
      end
      if (mw_sel.pair) dec[B_PV + int'(m_wait_peer)] = mw_hit;
    end

    for (int i = 0; i < NV; i++) begin
      v_vp_ok[i]   = |(vw_hit[i] & avail[B_VP + 2*i] & avail[B_VP + 2*i + 1]);
      v_fan_ok[i]  = |(vw_hit[i] & avail[B_FM + i]);
      v_pair_ok[i] = |(vw_hit[i] & avail[B_PM + i]);
      v_wait_ready[i] = (vw_sel[i].vpair && v_vp_ok[i]) ||
                        (vw_sel[i].fan   && v_fan_ok[i]) ||
                        (vw_sel[i].pair  && v_pair_ok[i]);
      if (v_wait_ready[i]) begin
        if (vw_sel[i].vpair) begin
          dec[B_VP + 2*i]     = vw_hit[i];
          dec[B_VP + 2*i + 1] = vw_hit[i];
        end
        if (vw_sel[i].fan)  dec[B_FM + i] = vw_hit[i];
        if (vw_sel[i].pair) dec[B_PM + i] = vw_hit[i];
      end
    end
  end

  // sticky overflow
  always_ff @(posedge clk) begin
    if (!rst_n) ovf_err <= 1'b0;
    else        ovf_err <= ovf_err | (|sat_v);
  end
endmodule

// File: rtl/xcore_flag_sync_chk.sv
module xcore_flag_sync_chk
  import xfs_pkg::*;
#(
  parameter int N_FLAGS = 11,
  parameter int ID_W    = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               m_set_valid,
  input logic [NV-1:0]      v_set_valid,
  input logic               m_wait_valid,
  input logic [1:0]         m_wait_mode,
  input logic [ID_W-1:0]    m_wait_id,
  input logic               m_wait_ready,
  input logic [NV-1:0]      v_wait_valid,
  input logic [2*NV-1:0]    v_wait_mode,
  input logic [NV*ID_W-1:0] v_wait_id,
  input logic [NV-1:0]      v_wait_ready,
  input logic               ovf_err
);
  p_m_ready_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    m_wait_ready |-> m_wait_valid);

  p_m_bad_id_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wait_id >= ID_W'(N_FLAGS)) |-> !m_wait_ready);

  p_m_bad_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wait_mode == 2'd3) |-> !m_wait_ready);

  p_m_vpair_never_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wait_mode == 2'd0) |-> !m_wait_ready);

  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  p_ovf_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_err) |-> $past(m_set_valid || (|v_set_valid)));

  for (genvar i = 0; i < NV; i++) begin : g_v
    p_v_ready_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
      v_wait_ready[i] |-> v_wait_valid[i]);

    p_v_bad_id_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (v_wait_id[ID_W*i +: ID_W] >= ID_W'(N_FLAGS)) |-> !v_wait_ready[i]);

    p_v_bad_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (v_wait_mode[2*i +: 2] == 2'd3) |-> !v_wait_ready[i]);
  end
endmodule

bind xcore_flag_sync xcore_flag_sync_chk #(.N_FLAGS(N_FLAGS), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_set_valid(m_set_valid), .v_set_valid(v_set_valid),
  .m_wait_valid(m_wait_valid), .m_wait_mode(m_wait_mode), .m_wait_id(m_wait_id),
  .m_wait_ready(m_wait_ready), .v_wait_valid(v_wait_valid), .v_wait_mode(v_wait_mode),
  .v_wait_id(v_wait_id), .v_wait_ready(v_wait_ready), .ovf_err(ovf_err));

// File: tb/xcore_flag_sync_test.sv
module xcore_flag_sync_test;
  localparam int NF = 11;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          sv  [3];
  logic [1:0]    smd [3];
  logic [IW-1:0] sid [3];
  logic          sp;
  logic          wv  [3];
  logic [1:0]    wmd [3];
  logic [IW-1:0] wid [3];
  logic          wp;
  logic          rdy0;
  logic [1:0]    vrdy;
  logic          ovf;

  xcore_flag_sync uut (
    .clk(clk), .rst_n(rst_n),
    .m_set_valid(sv[0]), .m_set_mode(smd[0]), .m_set_id(sid[0]), .m_set_peer(sp),
    .v_set_valid({sv[2], sv[1]}), .v_set_mode({smd[2], smd[1]}), .v_set_id({sid[2], sid[1]}),
    .m_wait_valid(wv[0]), .m_wait_mode(wmd[0]), .m_wait_id(wid[0]), .m_wait_peer(wp),
    .m_wait_ready(rdy0),
    .v_wait_valid({wv[2], wv[1]}), .v_wait_mode({wmd[2], wmd[1]}), .v_wait_id({wid[2], wid[1]}),
    .v_wait_ready(vrdy), .ovf_err(ovf));

  // reference: events outstanding per [mode][source core][dest core][flag]
  int cnt [4][3][3][16];
  bit exp_ovf;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int c = 0; c < 3; c++) begin
      sv[c] = 0; smd[c] = 0; sid[c] = 0; wv[c] = 0; wmd[c] = 0; wid[c] = 0;
    end
    sp = 0; wp = 0;
  endtask

  task automatic model_zero();
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 3; s++)
        for (int d = 0; d < 3; d++)
          for (int k = 0; k < 16; k++) cnt[m][s][d][k] = 0;
    exp_ovf = 0;
  endtask

  task automatic put_set(int c, int md, int id, bit p = 0);
    sv[c] = 1; smd[c] = 2'(md); sid[c] = IW'(id);
    if (c == 0) sp = p;
  endtask

  task automatic put_wait(int c, int md, int id, bit p = 0);
    wv[c] = 1; wmd[c] = 2'(md); wid[c] = IW'(id);
    if (c == 0) wp = p;
  endtask

  // one clock: compare at negedge+1, advance model at posedge
  task automatic step(string tag);
    int add [4][3][3][16];
    bit exp_r [3];
    int act_r [3];
    int m, k, s1, s2, v;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 3; b++)
        for (int d = 0; d < 3; d++)
          for (int e = 0; e < 16; e++) add[a][b][d][e] = 0;
    #1;
    for (int c = 0; c < 3; c++) begin
      m = int'(smd[c]); k = int'(sid[c]);
      if (sv[c] && m != 3 && k < NF) begin
        if (m == 0 && c != 0) begin add[0][c][1][k] = 1; add[0][c][2][k] = 1; end
        if (m == 1 && c == 0) begin add[1][0][1][k] = 1; add[1][0][2][k] = 1; end
        if (m == 1 && c != 0) add[1][c][0][k] = 1;
        if (m == 2 && c == 0) add[2][0][1 + int'(sp)][k] = 1;
        if (m == 2 && c != 0) add[2][c][0][k] = 1;
      end
    end
    for (int c = 0; c < 3; c++) begin
      exp_r[c] = 0; s1 = -1; s2 = -1;
      m = int'(wmd[c]); k = int'(wid[c]);
      if (wv[c] && m != 3 && k < NF) begin
        if (m == 0 && c != 0) begin s1 = 1; s2 = 2; end
        if (m == 1 && c == 0) begin s1 = 1; s2 = 2; end
        if (m == 1 && c != 0) s1 = 0;
        if (m == 2 && c == 0) s1 = 1 + int'(wp);
        if (m == 2 && c != 0) s1 = 0;
        if (s1 >= 0) begin
          exp_r[c] = (cnt[m][s1][c][k] + add[m][s1][c][k] > 0) &&
                     (s2 < 0 || cnt[m][s2][c][k] + add[m][s2][c][k] > 0);
          if (exp_r[c]) begin
            add[m][s1][c][k] -= 1;
            if (s2 >= 0) add[m][s2][c][k] -= 1;
          end
        end
      end
    end
    act_r[0] = int'(rdy0); act_r[1] = int'(vrdy[0]); act_r[2] = int'(vrdy[1]);
    chk(tag, "matrix wait ready", act_r[0], int'(exp_r[0]));
    chk(tag, "vector0 wait ready", act_r[1], int'(exp_r[1]));
    chk(tag, "vector1 wait ready", act_r[2], int'(exp_r[2]));
    chk(tag, "ovf_err", int'(ovf), int'(exp_ovf));
    @(posedge clk);
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 3; b++)
        for (int d = 0; d < 3; d++)
          for (int e = 0; e < 16; e++) begin
            v = cnt[a][b][d][e] + add[a][b][d][e];
            if (v > 15) begin v = 15; exp_ovf = 1; end
            cnt[a][b][d][e] = v;
          end
    @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      sv[c] = 0;
      if (exp_r[c]) wv[c] = 0;
    end
  endtask

  task automatic do_reset();
    clear_all();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_zero();
  endtask

  initial begin
    clear_all();
    model_zero();
    do_reset();

    // R1: idle after reset
    step("R1"); step("R1");

    // R3: wait with nothing stored stalls while held
    put_wait(1, 1, 3);
    repeat (3) step("R3");

    // R5: matrix fan set meets the held vector0 wait on an empty counter
    put_set(0, 1, 3);
    step("R5");
    // R7: vector1 consumes its own copy of the same fan event
    put_wait(2, 1, 3);
    step("R7");

    // R2: three stored one-to-one events release three waits, fourth stalls
    for (int n = 0; n < 3; n++) begin put_set(0, 2, 5, 0); step("R2"); end
    for (int n = 0; n < 4; n++) begin put_wait(1, 2, 5); step("R2"); end
    step("R2");
    put_set(0, 2, 5, 0);
    step("R5");

    // R8: matrix fan wait needs both vectors
    put_set(1, 1, 7); step("R8");
    put_wait(0, 1, 7); step("R8"); step("R8");
    put_set(2, 1, 7); step("R8");

    // R6: vector pair mode
    put_set(1, 0, 1); step("R6");
    put_wait(2, 0, 1); step("R6");
    put_set(2, 0, 1); step("R6");
    put_wait(1, 0, 1); step("R6");
    put_set(0, 0, 1); step("R6");
    put_wait(0, 0, 1); step("R6"); step("R6");
    wv[0] = 0; step("R12");

    // R9: one-to-one peer selection
    put_set(2, 2, 2); step("R9");
    put_wait(0, 2, 2, 0); step("R9"); step("R9");
    wv[0] = 0; step("R12");
    put_wait(0, 2, 2, 1); step("R9");
    put_set(0, 2, 8, 1); step("R9");
    put_wait(1, 2, 8); step("R9"); wv[1] = 0;
    put_wait(2, 2, 8); step("R9");

    // R10: same flag number, other mode
    put_set(0, 1, 4); step("R10");
    put_wait(1, 2, 4); step("R10"); wv[1] = 0;
    put_wait(1, 1, 4); step("R10");
    put_wait(2, 1, 4); step("R10");

    // R11: reserved mode and out-of-range flags
    put_set(1, 3, 6); put_set(2, 1, 12); put_set(0, 3, 6); step("R11");
    put_wait(1, 3, 6); put_wait(2, 1, 12); put_wait(0, 2, 6, 0); step("R11"); step("R11");
    clear_all();

    // R4: sixteen sets on one counter, then releases
    for (int n = 0; n < 16; n++) begin put_set(1, 2, 9); step("R4"); end
    step("R4");
    for (int n = 0; n < 16; n++) begin put_wait(0, 2, 9, 0); step("R4"); end
    wv[0] = 0;
    // R5: set and release together at the ceiling
    for (int n = 0; n < 15; n++) begin put_set(2, 2, 10); step("R5"); end
    put_set(2, 2, 10); put_wait(0, 2, 10, 1); step("R5");
    step("R5");

    // R12: random mix against the reference
    for (int n = 0; n < 600; n++) begin
      for (int c = 0; c < 3; c++) begin
        if ($urandom % 3 == 0) put_set(c, $urandom % 4, ($urandom % 8 == 0) ? 11 : $urandom % 4, 1'($urandom));
        if (!wv[c] && $urandom % 3 == 0) put_wait(c, $urandom % 4, ($urandom % 8 == 0) ? 12 : $urandom % 4, 1'($urandom));
        else if (wv[c] && $urandom % 16 == 0) wv[c] = 0;
      end
      step("R12");
    end

    // R1: reset clears the overflow flag and all counters
    do_reset();
    step("R1");
    put_wait(1, 1, 3); put_wait(0, 2, 9, 0); step("R1");
    clear_all();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule